// File: doc/BRIEF.md
# Record Block Buffer with Controlled Flush

This block sits between a stream of decoded bytes and a storage writer that works in fixed-size blocks. Bytes arrive one per cycle with a valid strobe. They are packed in arrival order into 512-byte blocks, and each full block raises a write request toward the storage side. Two block banks are used in alternation. While the writer is busy reading one bank, new bytes fill the other, so a slow writer does not cost any data as long as it finishes before the second bank is full.

The writer reads the requested block by address through a combinational read port. It then acknowledges the request, and that frees the bank. Shutdown is controlled. A stop request seals the block that is filling, if it holds any bytes. Addresses past the last stored byte of that block read as 0x00 padding. The block is requested like any other. The done output rises only after every outstanding block has been acknowledged, and it stays high until reset. If the current block is empty when stop arrives, no extra write is issued.

Top module: `rec_block_buffer`

## Requirements
- R1: After reset, wrReq and done are both 0.
- R2: The k-th byte accepted into a block (k counted from 0) reads back on rdData when rdAddr = k while that block is requested.
- R3: The cycle after the byte that fills a block of BLOCK_BYTES is accepted, wrReq is 1. wrReq stays 1 until a cycle in which wrAck is 1.
- R4: A wrAck while wrReq is 1 releases the requested block. Blocks are requested in the order they were filled. wrReq drops after the acknowledge only if no other block is waiting.
- R5: Bytes that arrive while one block awaits writing go into the other bank. A byte that arrives while both banks await writing is discarded.
- R6: A stop request while the filling block holds L bytes (0 < L < BLOCK_BYTES) seals that block and requests it. Addresses L and above read 0x00.
- R7: A stop request while the filling block is empty issues no write. With nothing outstanding, done rises on the second clock edge after the stop cycle.
- R8: done rises only the cycle after the last outstanding block is acknowledged. It then stays 1 until reset. Bytes and stop requests after the stop cycle cause no new write request.
- R9: A byte presented in the same cycle as the stop request is included in the flushed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inByte | input | DATA_W | Incoming byte |
| inValid | input | 1 | inByte holds a byte this cycle |
| stopReq | input | 1 | Begin controlled shutdown |
| wrReq | output | 1 | A sealed block awaits writing |
| wrAck | input | 1 | Writer has consumed the requested block |
| rdAddr | input | log2(BLOCK_BYTES) | Byte address within the requested block |
| rdData | output | DATA_W | Byte at rdAddr, or 0x00 beyond the block's stored length |
| done | output | 1 | Shutdown and final flush complete |

## Verification
The hardest situation to reach is the one where both banks are sealed at the same time and a further byte arrives and must be dropped. The bench gets there by holding wrAck low across two full blocks, offering one extra byte, and then draining both banks in order. A sweep over every stop position across three blocks, in a small eight-byte configuration, covers the empty-block case, every partial length with its zero padding, and the case where stop lands exactly on a block boundary.

// File: rtl/rbb_pkg.sv
`timescale 1ns/1ps
package rbb_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_DONE  = 2'd2
  } rbbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic wrBank;
    logic sealEn;
    logic sealBank;
    logic rdBank;
  } rbbStrobe_t;
endpackage

// File: rtl/rbb_datapath.sv
`timescale 1ns/1ps
module rbb_datapath
  import rbb_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int LEN_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbbStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  sealLen,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bankRd  [NUM_BANKS];
  logic [LEN_W-1:0]  bankLen [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] store [BLOCK_BYTES];
    logic [LEN_W-1:0]  lenQ;

    always_ff @(posedge clk) begin
      if (strb.wrEn && strb.wrBank == 1'(b)) store[wrAddr] <= wrData;
    end

    // stored length of a sealed block; reads past it return padding
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lenQ <= '0;
      else if (strb.sealEn && strb.sealBank == 1'(b)) lenQ <= sealLen;
    end

    assign bankRd[b]  = store[rdAddr];
    assign bankLen[b] = lenQ;
  end

  always_comb begin
    if ({1'b0, rdAddr} < bankLen[strb.rdBank]) rdData = bankRd[strb.rdBank];
    else                                       rdData = '0;
  end
endmodule

// File: rtl/rbb_control.sv
`timescale 1ns/1ps
module rbb_control
  import rbb_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int LEN_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              stopReq,
  input  logic              wrAck,
  output rbbStrobe_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LEN_W-1:0]  sealLen,
  output logic              wrReq,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BLOCK_BYTES - 1);
  localparam logic [LEN_W-1:0]  FULL_LEN  = LEN_W'(BLOCK_BYTES);

  rbbState_t         state;
  logic              fillBank;
  logic [ADDR_W-1:0] fillCount;
  logic [1:0]        pending;
  logic              reqBank;

  logic isRun, accept, fillsBlock, flushPart, seal, ackTake;
  logic [1:0] pendingNext;

  always_comb begin
    isRun      = (state == ST_RUN);
    accept     = isRun && inValid && !pending[fillBank];
    fillsBlock = accept && (fillCount == LAST_ADDR);
    flushPart  = isRun && stopReq && !fillsBlock && ((fillCount != '0) || accept);
    seal       = fillsBlock || flushPart;
    ackTake    = wrAck && pending[reqBank];

    pendingNext = pending;
    if (ackTake) pendingNext[reqBank] = 1'b0;
    if (seal)    pendingNext[fillBank] = 1'b1;

    sealLen = fillsBlock ? FULL_LEN : (LEN_W'(fillCount) + LEN_W'(accept));

    strb.wrEn     = accept;
    strb.wrBank   = fillBank;
    strb.sealEn   = seal;
    strb.sealBank = fillBank;
    strb.rdBank   = reqBank;
    wrAddr        = fillCount;
    wrReq         = pending[reqBank];
    done          = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      fillBank  <= 1'b0;
      fillCount <= '0;
      pending   <= '0;
      reqBank   <= 1'b0;
    end else begin
      pending <= pendingNext;
      if (ackTake) reqBank <= ~reqBank;
      if (seal) begin
        fillBank  <= ~fillBank;
        fillCount <= '0;
      end else if (accept) begin
        fillCount <= fillCount + 1'b1;
      end
      unique case (state)
        ST_RUN:   if (stopReq) state <= ST_DRAIN;
        ST_DRAIN: if (pending == '0) state <= ST_DONE;
        ST_DONE:  state <= ST_DONE;
        default:  state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rec_block_buffer.sv
`timescale 1ns/1ps
module rec_block_buffer
  import rbb_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int DATA_W      = 8,
  localparam int ADDR_W     = $clog2(BLOCK_BYTES),
  localparam int LEN_W      = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  input  logic              stopReq,
  output logic              wrReq,
  input  logic              wrAck,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  rbbStrobe_t        strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [LEN_W-1:0]  sealLen;

  rbb_control #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stopReq(stopReq),
    .wrAck(wrAck), .strb(strb), .wrAddr(wrAddr), .sealLen(sealLen),
    .wrReq(wrReq), .done(done)
  );

  rbb_datapath #(.BLOCK_BYTES(BLOCK_BYTES), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(inByte),
    .sealLen(sealLen), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/rbb_checker.sv
`timescale 1ns/1ps
module rbb_checker (
  input logic clk,
  input logic rstN,
  input logic stopReq,
  input logic wrReq,
  input logic wrAck,
  input logic done
);
  logic sawStop;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        sawStop <= 1'b0;
    else if (stopReq) sawStop <= 1'b1;
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq);

  p_done_after_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sawStop);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  p_done_no_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrReq);

  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(!wrReq));
endmodule

bind rec_block_buffer rbb_checker u_chk (
  .clk(clk), .rstN(rstN), .stopReq(stopReq),
  .wrReq(wrReq), .wrAck(wrAck), .done(done)
);

// File: tb/sim_rec_block_buffer.sv
`timescale 1ns/1ps
module sim_rec_block_buffer;
  localparam int BLK      = 8;
  localparam int AW       = $clog2(BLK);
  localparam int CLK_PER  = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    inByte = '0;
  logic          inValid = 1'b0;
  logic          stopReq = 1'b0;
  logic          wrReq;
  logic          wrAck = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdData;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  rec_block_buffer #(.BLOCK_BYTES(BLK), .DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .stopReq(stopReq), .wrReq(wrReq), .wrAck(wrAck),
    .rdAddr(rdAddr), .rdData(rdData), .done(done)
  );

  function automatic logic [7:0] pat(int s);
    return 8'((s * 37 + 11) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; stopReq = 1'b0; wrAck = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(wrReq == 1'b0, "R1 wrReq", int'(wrReq), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
  endtask

  task automatic sendByte(logic [7:0] v);
    inByte = v; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic pulseAck();
    wrAck = 1'b1;
    @(negedge clk);
    wrAck = 1'b0;
  endtask

  task automatic pulseStop();
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  // writer model: read every address of the requested block
  task automatic readBlock(int startSeq, int len);
    for (int a = 0; a < BLK; a++) begin
      rdAddr = AW'(a);
      #1;
      if (a < len)
        check(rdData == pat(startSeq + a), "R2 data", int'(rdData), int'(pat(startSeq + a)));
      else
        check(rdData == 8'h00, "R6 pad", int'(rdData), 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // sweep every stop position over three blocks, fast writer
    for (int n = 0; n <= 3 * BLK; n++) begin
      doReset();
      for (int i = 0; i < n; i++) begin
        sendByte(pat(i));
        if ((i + 1) % BLK == 0) begin
          check(wrReq == 1'b1, "R3 full request", int'(wrReq), 1);
          readBlock(i + 1 - BLK, BLK);
          check(wrReq == 1'b1, "R3 held", int'(wrReq), 1);
          pulseAck();
          check(wrReq == 1'b0, "R4 released", int'(wrReq), 0);
        end
      end
      pulseStop();
      if (n % BLK != 0) begin
        check(wrReq == 1'b1, "R6 flush request", int'(wrReq), 1);
        check(done == 1'b0, "R8 done early", int'(done), 0);
        readBlock(n - (n % BLK), n % BLK);
        pulseAck();
        check(done == 1'b0, "R8 done at ack", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R8 done after ack", int'(done), 1);
      end else begin
        check(wrReq == 1'b0, "R7 no write", int'(wrReq), 0);
        check(done == 1'b0, "R7 done first edge", int'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R7 done second edge", int'(done), 1);
      end
      sendByte(8'h55);
      pulseStop();
      repeat (3) @(negedge clk);
      check(wrReq == 1'b0, "R8 ignored after stop", int'(wrReq), 0);
      check(done == 1'b1, "R8 sticky", int'(done), 1);
    end

    // both banks sealed, extra byte dropped (R5)
    doReset();
    for (int i = 0; i < 2 * BLK; i++) sendByte(pat(i));
    sendByte(8'hEE);
    repeat (4) @(negedge clk);
    check(wrReq == 1'b1, "R3 held without ack", int'(wrReq), 1);
    readBlock(0, BLK);
    pulseAck();
    check(wrReq == 1'b1, "R4 second block waiting", int'(wrReq), 1);
    readBlock(BLK, BLK);
    pulseAck();
    check(wrReq == 1'b0, "R5 dropped byte no block", int'(wrReq), 0);
    pulseStop();
    check(wrReq == 1'b0, "R5 dropped byte not flushed", int'(wrReq), 0);
    @(negedge clk);
    check(done == 1'b1, "R7 done", int'(done), 1);

    // byte in the stop cycle is flushed (R9), later input ignored
    doReset();
    sendByte(pat(100));
    sendByte(pat(101));
    inByte = pat(102); inValid = 1'b1; stopReq = 1'b1;
    @(negedge clk);
    inValid = 1'b0; stopReq = 1'b0;
    check(wrReq == 1'b1, "R9 flush request", int'(wrReq), 1);
    sendByte(8'hAA);
    sendByte(8'hBB);
    readBlock(100, 3);
    rdAddr = AW'(2); #1;
    check(rdData == pat(102), "R9 stop-cycle byte", int'(rdData), int'(pat(102)));
    @(negedge clk);
    pulseAck();
    @(negedge clk);
    check(wrReq == 1'b0, "R8 no request after drain", int'(wrReq), 0);
    check(done == 1'b1, "R8 done", int'(done), 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule